// File: doc/BRIEF.md
# Fixed-Point Operand Normalization Shift Generator

This block prepares an unsigned fixed-point operand for a reciprocal or reciprocal-square-root kernel that only handles a narrow input range. It finds the highest set bit of the operand and measures where that bit sits relative to the binary point. From that position it derives two things. The first is a scaling shift, which moves the operand into the kernel's 20-bit working format (3 integer bits, 17 fractional bits). The second is a de-scaling shift amount and direction, which the caller keeps and later uses to bring the kernel's result back to the operand's scale.

A mode input selects how the exponent is handled. In reciprocal mode the operand is placed in [1, 2). In square-root mode the exponent is first forced to an even value, so the operand is placed in [1, 4), and the de-scaling amount is half of that even exponent.

The same logarithmic shifter design is instantiated a second time as a de-scaling path. That path shifts a kernel result by caller-supplied controls. All outputs are registered, with one cycle of latency and a synchronous active-high reset.

Top module: `norm_shift_gen`

## Requirements
- R1: While reset is held, every output is zero.
- R2: With mode_rec=1 and a nonzero operand, scaled_out one cycle later holds the operand shifted so that its highest set bit lands on bit 17 (value 1.0). scaled_out is therefore in [1, 2).
- R3: With mode_rec=0 and a nonzero operand, the position P is rounded down to the nearest even number Pe. The operand is scaled by 2^-Pe, so its highest set bit lands on bit 17 when P is even and on bit 18 when P is odd.
- R4: With mode_rec=1, dsc_amt equals |P|. Here P = (index of highest set bit) − F, and F is the fractional-bit count (default 16).
- R5: With mode_rec=0, dsc_amt equals |Pe|/2.
- R6: For a nonzero operand, dsc_left is 1 exactly when P is negative. A value of 1 means the kernel result must be shifted left.
- R7: An all-zero operand sets zero_op one cycle later and forces scaled_out, dsc_amt and dsc_left to zero. A nonzero operand clears zero_op.
- R8: kres_out one cycle later equals kres_in logically shifted by kres_amt, left when kres_left=1 and right otherwise. The shift fills with zeros, keeps 20 bits, and gives zero for amounts of 20 or more.
- R9: In the default format, scaling never drops a set bit. The count of ones in scaled_out equals the count of ones in the operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_in | input | W | Unsigned operand, F fractional bits |
| mode_rec | input | 1 | 1 = reciprocal/divide, 0 = reciprocal square root/square root |
| kres_in | input | 20 | Kernel result in working format |
| kres_amt | input | DAW | De-scaling amount to apply to kres_in |
| kres_left | input | 1 | De-scaling direction for kres_in, 1 = left |
| scaled_out | output | 20 | Normalized operand, 3 integer / 17 fractional bits |
| dsc_amt | output | DAW | De-scaling magnitude for this operand |
| dsc_left | output | 1 | De-scaling direction for this operand, 1 = left |
| zero_op | output | 1 | Operand was zero |
| kres_out | output | 20 | De-scaled kernel result |

## Verification
Several properties are checked on every cycle. The normalized operand must land in the window its mode demands, with bit 17 as the top bit in reciprocal mode and bit 17 or 18 in square-root mode. The zero flag must follow the operand and clear the shift outputs, and a left de-scale must never carry a zero amount. The set-bit count must survive scaling. The exact shift amounts, the even rounding of odd exponents, the halving in square-root mode and the de-scaling shifter's results at 0, mid-range and out-of-range amounts can only be shown by the bench's scenarios. These include a sweep of every single-bit operand in both modes.

// File: rtl/nsg_pkg.sv
package nsg_pkg;
  localparam int WORK_INT  = 3;
  localparam int WORK_FRAC = 17;
  localparam int WORK_W    = WORK_INT + WORK_FRAC;

  typedef enum logic {
    MODE_RSQRT = 1'b0,
    MODE_RECIP = 1'b1
  } norm_mode_e;
endpackage

// File: rtl/nsg_lead_one.sv
module nsg_lead_one #(
  parameter int W   = 16,
  parameter int IXW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]   vec,
  output logic [IXW-1:0] idx,
  output logic           found
);
  // Highest set bit wins: later iterations overwrite earlier ones.
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        idx   = IXW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/nsg_exp_calc.sv
module nsg_exp_calc
  import nsg_pkg::*;
#(
  parameter int W   = 16,
  parameter int F   = 16,
  parameter int IXW = 4,
  parameter int SAW = 6,
  parameter int DAW = 6
) (
  input  logic [IXW-1:0] idx,
  input  logic           found,
  input  norm_mode_e     mode,
  output logic [SAW-1:0] sc_amt,
  output logic           sc_left,
  output logic [DAW-1:0] ds_amt,
  output logic           ds_left
);
  localparam int EW = $clog2(W + F + WORK_W + 1) + 2;
  // Offset between the operand LSB weight and the working-format LSB weight.
  localparam logic signed [EW-1:0] LSB_OFS = EW'(WORK_FRAC - F);
  localparam logic signed [EW-1:0] F_S     = EW'(F);

  logic signed [EW-1:0] pos, pev, sexp, sabs, dmag, dabs;

  always_comb begin
    pos  = $signed({{(EW-IXW){1'b0}}, idx}) - F_S;
    // Square-root mode: round down to even (clear LSB in two's complement).
    pev  = (mode == MODE_RECIP) ? pos : (pos & ~EW'(1));
    sexp = LSB_OFS - pev;
    sabs = sexp[EW-1] ? -sexp : sexp;
    dmag = (mode == MODE_RECIP) ? pev : (pev >>> 1);
    dabs = dmag[EW-1] ? -dmag : dmag;
    if (found) begin
      sc_left = ~sexp[EW-1];
      sc_amt  = SAW'(sabs);
      ds_left = pos[EW-1];
      ds_amt  = DAW'(dabs);
    end else begin
      sc_left = 1'b0;
      sc_amt  = '0;
      ds_left = 1'b0;
      ds_amt  = '0;
    end
  end
endmodule

// File: rtl/nsg_barrel.sv
module nsg_barrel #(
  parameter int DW = 20,
  parameter int AW = 5
) (
  input  logic [DW-1:0] din,
  input  logic [AW-1:0] amt,
  input  logic          left,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] stg [0:AW];

  assign stg[0] = din;

  for (genvar g = 0; g < AW; g++) begin : g_stage
    assign stg[g+1] = amt[g] ? (left ? (stg[g] << (2**g)) : (stg[g] >> (2**g)))
                             : stg[g];
  end

  assign dout = stg[AW];
endmodule

// File: rtl/norm_shift_gen.sv
module norm_shift_gen
  import nsg_pkg::*;
#(
  parameter int W   = 16,
  parameter int F   = 16,
  parameter int DAW = $clog2(W + F + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      op_in,
  input  logic              mode_rec,
  input  logic [WORK_W-1:0] kres_in,
  input  logic [DAW-1:0]    kres_amt,
  input  logic              kres_left,
  output logic [WORK_W-1:0] scaled_out,
  output logic [DAW-1:0]    dsc_amt,
  output logic              dsc_left,
  output logic              zero_op,
  output logic [WORK_W-1:0] kres_out
);
  localparam int IXW = (W > 1) ? $clog2(W) : 1;
  localparam int XW  = W + WORK_W;
  localparam int SAW = $clog2(XW + 1);

  logic [IXW-1:0]    lead_idx;
  logic              lead_found;
  logic [SAW-1:0]    sc_amt;
  logic              sc_left;
  logic [DAW-1:0]    ds_amt;
  logic              ds_left;
  logic [XW-1:0]     sc_wide;
  logic [WORK_W-1:0] kres_sh;
  norm_mode_e        mode;

  assign mode = norm_mode_e'(mode_rec);

  nsg_lead_one #(.W(W), .IXW(IXW)) u_lead (
    .vec   (op_in),
    .idx   (lead_idx),
    .found (lead_found)
  );

  nsg_exp_calc #(.W(W), .F(F), .IXW(IXW), .SAW(SAW), .DAW(DAW)) u_exp (
    .idx     (lead_idx),
    .found   (lead_found),
    .mode    (mode),
    .sc_amt  (sc_amt),
    .sc_left (sc_left),
    .ds_amt  (ds_amt),
    .ds_left (ds_left)
  );

  nsg_barrel #(.DW(XW), .AW(SAW)) u_scale_sh (
    .din  ({{WORK_W{1'b0}}, op_in}),
    .amt  (sc_amt),
    .left (sc_left),
    .dout (sc_wide)
  );

  nsg_barrel #(.DW(WORK_W), .AW(DAW)) u_descale_sh (
    .din  (kres_in),
    .amt  (kres_amt),
    .left (kres_left),
    .dout (kres_sh)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scaled_out <= '0;
      dsc_amt    <= '0;
      dsc_left   <= 1'b0;
      zero_op    <= 1'b0;
      kres_out   <= '0;
    end else begin
      scaled_out <= sc_wide[WORK_W-1:0];
      dsc_amt    <= ds_amt;
      dsc_left   <= ds_left;
      zero_op    <= ~lead_found;
      kres_out   <= kres_sh;
    end
  end
endmodule

// File: rtl/norm_shift_gen_chk.sv
module norm_shift_gen_chk
  import nsg_pkg::*;
#(
  parameter int W   = 16,
  parameter int DAW = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [W-1:0]      op_in,
  input logic              mode_rec,
  input logic [WORK_W-1:0] scaled_out,
  input logic [DAW-1:0]    dsc_amt,
  input logic              dsc_left,
  input logic              zero_op
);
  logic armed;
  always_ff @(posedge clk) armed <= ~rst;

  // R7
  p_zero_clears_r7: assert property (@(posedge clk) disable iff (rst)
    zero_op |-> (scaled_out == '0 && dsc_amt == '0 && !dsc_left));

  p_zero_follows_r7: assert property (@(posedge clk) disable iff (rst)
    armed |-> (zero_op == ($past(op_in) == '0)));

  // R2
  p_rec_window_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && !zero_op && $past(mode_rec)) |-> (scaled_out[WORK_W-1:WORK_FRAC] == 3'b001));

  // R3
  p_rsq_window_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && !zero_op && !$past(mode_rec)) |->
      (!scaled_out[WORK_W-1] && scaled_out[WORK_FRAC+1:WORK_FRAC] != 2'b00));

  // R6
  p_left_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    (armed && dsc_left) |-> (dsc_amt != '0));

  // R9
  p_bits_kept_r9: assert property (@(posedge clk) disable iff (rst)
    armed |-> ($countones(scaled_out) == $countones($past(op_in))));
endmodule

bind norm_shift_gen norm_shift_gen_chk #(.W(W), .DAW(DAW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_in      (op_in),
  .mode_rec   (mode_rec),
  .scaled_out (scaled_out),
  .dsc_amt    (dsc_amt),
  .dsc_left   (dsc_left),
  .zero_op    (zero_op)
);

// File: tb/sim_norm_shift_gen.sv
module sim_norm_shift_gen;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 16;
  localparam int F   = 16;
  localparam int DAW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  op_in = '0;
  logic          mode_rec = 1'b0;
  logic [19:0]   kres_in = '0;
  logic [DAW-1:0] kres_amt = '0;
  logic          kres_left = 1'b0;
  logic [19:0]   scaled_out;
  logic [DAW-1:0] dsc_amt;
  logic          dsc_left;
  logic          zero_op;
  logic [19:0]   kres_out;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [19:0]    sc;
    logic [DAW-1:0] amt;
    logic           left;
    logic           z;
    logic [19:0]    ko;
    string          tag;
  } exp_t;

  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  norm_shift_gen #(.W(W), .F(F)) u0 (
    .clk(clk), .rst(rst), .op_in(op_in), .mode_rec(mode_rec),
    .kres_in(kres_in), .kres_amt(kres_amt), .kres_left(kres_left),
    .scaled_out(scaled_out), .dsc_amt(dsc_amt), .dsc_left(dsc_left),
    .zero_op(zero_op), .kres_out(kres_out)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(logic [W-1:0] op, logic mrec, logic [19:0] kr,
                                 logic [DAW-1:0] ka, logic kl, string tag);
    exp_t e;
    int k, p, pe, s, dm;
    logic [39:0] wide;
    e.tag = tag;
    e.ko  = kl ? 20'(kr << ka) : (kr >> ka);
    if (op == '0) begin
      e.sc = '0; e.amt = '0; e.left = 1'b0; e.z = 1'b1;
    end else begin
      k = 0;
      for (int i = 0; i < W; i++) if (op[i]) k = i;
      p  = k - F;
      pe = (mrec || (p % 2 == 0)) ? p : p - 1;
      s  = 17 - F - pe;
      wide = 40'(op);
      wide = (s >= 0) ? (wide << s) : (wide >> (-s));
      e.sc = wide[19:0];
      dm = mrec ? p : pe / 2;
      e.amt  = DAW'((dm < 0) ? -dm : dm);
      e.left = (p < 0);
      e.z    = 1'b0;
    end
    return e;
  endfunction

  task automatic apply(logic [W-1:0] op, logic mrec, logic [19:0] kr,
                       logic [DAW-1:0] ka, logic kl, string tag);
    @(negedge clk);
    op_in = op; mode_rec = mrec; kres_in = kr; kres_amt = ka; kres_left = kl;
    q.push_back(model(op, mrec, kr, ka, kl, tag));
  endtask

  // Monitor: compares each registered result one edge after it was driven.
  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.tag, " scaled"}, 32'(scaled_out), 32'(e.sc));
      check({e.tag, " amount"}, 32'(dsc_amt), 32'(e.amt));
      check({e.tag, " left"}, 32'(dsc_left), 32'(e.left));
      check({e.tag, " zero"}, 32'(zero_op), 32'(e.z));
      check({e.tag, " kres R8"}, 32'(kres_out), 32'(e.ko));
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    op_in = 16'hFFFF; kres_in = 20'hFFFFF; mode_rec = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs held at zero under reset despite active inputs
    check("R1 scaled", 32'(scaled_out), 0);
    check("R1 amount", 32'(dsc_amt), 0);
    check("R1 left", 32'(dsc_left), 0);
    check("R1 zero", 32'(zero_op), 0);
    check("R1 kres", 32'(kres_out), 0);
    rst = 1'b0;

    // R2 / R4 reciprocal mode
    apply(16'h8000, 1'b1, 20'hABCDE, 6'd4, 1'b1, "R2 R4 rec 0x8000");
    apply(16'h0001, 1'b1, 20'hABCDE, 6'd4, 1'b0, "R2 R4 rec 0x0001");
    apply(16'hFFFF, 1'b1, 20'h12345, 6'd0, 1'b1, "R2 R4 rec 0xFFFF");
    apply(16'h0003, 1'b1, 20'h80001, 6'd19, 1'b0, "R2 R4 R6 rec 0x0003");
    // R3 / R5 square-root mode, even and odd exponents
    apply(16'h4000, 1'b0, 20'h80001, 6'd19, 1'b1, "R3 R5 rsq even P");
    apply(16'h8000, 1'b0, 20'hFFFFF, 6'd20, 1'b1, "R3 R5 rsq odd P");
    apply(16'h0001, 1'b0, 20'hFFFFF, 6'd63, 1'b0, "R3 R5 rsq 0x0001");
    apply(16'h00A5, 1'b0, 20'h0F0F0, 6'd8, 1'b0, "R3 R5 R9 rsq 0x00A5");
    // R7 zero operand in both modes
    apply(16'h0000, 1'b1, 20'h00001, 6'd1, 1'b1, "R7 zero rec");
    apply(16'h0000, 1'b0, 20'h00001, 6'd1, 1'b1, "R7 zero rsq");
    apply(16'h1234, 1'b1, 20'h00001, 6'd1, 1'b1, "R7 R9 nonzero after zero");
    // R2..R6 sweep of every single-bit operand in both modes
    for (int b = 0; b < W; b++) begin
      apply(16'(1) << b, 1'b1, 20'(b), 6'(b), b[0], "R2 R4 R6 sweep rec");
      apply(16'(1) << b, 1'b0, 20'(b), 6'(b), ~b[0], "R3 R5 R6 sweep rsq");
    end
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule